// File: doc/BRIEF.md
# Pointer-List Copy Channel

This block is one channel of a memory-to-memory copy engine. Software hands it a list address through a command-pointer register. The channel then reads a list of 32-bit pointer entries from memory. Each entry points to an array of four-word copy commands, and the channel carries out each command by reading source words and writing them to the destination. Both the pointer list and each command array end at an entry whose bit 31 is set.

Completion and abnormal ends are reported as 32-bit result words in a small queue that software drains by reading a register. A status word shows how many results are queued and how many list pointers are held. An interrupt line is raised while results are waiting, if software has enabled it. Memory is reached through one word-wide port with a request/acknowledge handshake and one access in flight at a time.

Register offsets on `reg_addr`:
- 0: command pointer (write).
- 1: result (read; a read pops one entry).
- 2: status (read).
- 3: config (read/write).
- 4: flush (write).

Top module: `dlw_channel`

## Requirements
- R1: After reset, status (offset 2) reads 0x00000001, a result read (offset 1) returns 0, `irq` is low and `mem_req` is low.
- R2: A write to offset 0 is taken only when bits 31:29 equal 1 and the one-entry pointer slot is free. The list address becomes bits 28:0 shifted left by 3. Writes with any other type value, or writes made while the slot is full, are ignored. The channel starts a walk from the slot whenever it is idle.
- R3: A pointer entry's bit 31 marks the last entry, and bits 28:0 shifted left by 3 give the command array address. Bits 30:29 are ignored. Successive entries sit at consecutive words.
- R4: A command is four consecutive words: control, source byte address, destination byte address, byte length. In single mode (control bits 1:0 = 0) the channel copies ceil(length/4) words in ascending order. A length of zero moves no data.
- R5: Bit 31 of the control word ends the current array. The walk then fetches the next pointer entry, or finishes if the current entry carried the last mark.
- R6: A control word whose bits 1:0 are nonzero performs no copy, pushes result 0x80000008 (valid and error), and ends the walk.
- R7: When the command array of the last pointer entry completes, result 0x80000002 (valid and done) is pushed.
- R8: Control bit 22 makes the channel push 0x80000001 (valid and user) once that command's copy completes, ahead of any result produced later.
- R9: Status layout: bits 31:29 hold the queued result count, bits 28:27 the number of held list pointers (walk in progress plus slot), bit 1 is set when a result is queued, bit 0 is set when the pointer slot is free, and all other bits are 0.
- R10: `irq` is high exactly while config bit 0 (offset 3) is set and the result queue is not empty.
- R11: With config bit 2 set, a done result 0x80000002 is also pushed when the array of each non-final pointer entry completes.
- R12: A write to offset 4 during a walk stops it at the next command boundary, after the command in progress has finished. With config bit 1 set, the result 0x80000004 (valid and flush) is pushed; otherwise no result is pushed.
- R13: The result queue holds 4 entries in arrival order, and a read of offset 1 pops the head. A read of an empty queue returns 0 with bit 31 clear. When the queue is full, the walk waits and loses no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the result queue at offset 1) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Result-waiting interrupt |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | High for a write access |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes in this cycle |

## Verification
A walker that lands in the wrong state shows up first on the memory port: an address outside the expected list, array or buffer range appears within a few cycles. A skipped or extra command shows later, as a destination word that differs from its source or a sentinel word that has been overwritten, once the list ends. Errors in result ordering or queue counting appear on the next result or status read. A lost stall appears as a missing result after software has drained a full queue.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  localparam int          TYPE_LO       = 29;
  localparam logic [2:0]  TYPE_PTR_LIST = 3'd1;
  localparam int          LAST_BIT      = 31;
  localparam int          FORCE_BIT     = 22;
  localparam int          RB_VALID      = 31;
  localparam int          RB_ERR        = 3;
  localparam int          RB_FLUSH      = 2;
  localparam int          RB_DONE       = 1;
  localparam int          RB_USER       = 0;
  localparam int          CF_IRQ        = 0;
  localparam int          CF_FLUSH_RES  = 1;
  localparam int          CF_TOP_RES    = 2;

  typedef enum logic [2:0] {
    RA_CMDPTR = 3'd0,
    RA_RESULT = 3'd1,
    RA_STATUS = 3'd2,
    RA_CONFIG = 3'd3,
    RA_FLUSH  = 3'd4
  } reg_addr_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PTR, ST_CMD, ST_DEC, ST_RD, ST_WR, ST_FIN, ST_ADV, ST_PUSH
  } walk_st_e;

  // 8-byte aligned address from a 29-bit field
  function automatic logic [31:0] field_to_addr(input logic [28:0] f);
    return {f, 3'b000};
  endfunction

  // number of words a byte length covers, rounded up
  function automatic logic [29:0] words_of(input logic [31:0] len);
    return len[31:2] + 30'(|len[1:0]);
  endfunction

  function automatic logic [31:0] result_word(input logic err, input logic fl,
                                              input logic done, input logic user);
    logic [31:0] w;
    w = '0;
    w[RB_VALID] = 1'b1;
    w[RB_ERR]   = err;
    w[RB_FLUSH] = fl;
    w[RB_DONE]  = done;
    w[RB_USER]  = user;
    return w;
  endfunction
endpackage

// File: rtl/dlw_resq.sv
module dlw_resq #(
  parameter  int DEPTH = 4,
  parameter  int W     = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = store[rp];

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r13_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r13_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/dlw_walker.sv
module dlw_walker
  import dlw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_addr,
  input  logic        flush_req,
  input  logic        cfg_flush_res,
  input  logic        cfg_top_res,
  input  logic        res_full,
  output logic        busy,
  output logic        res_push,
  output logic [31:0] res_word,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  walk_st_e    st, st_after;
  logic [31:0] ptr_a, cmd_a, src_a, dst_a, cw, dbuf, res_q;
  logic [29:0] left;
  logic [1:0]  idx;
  logic        last_ptr, flush_pend;
  logic        beat;       // access accepted this cycle
  logic        mode_bad;   // decoded command is not single mode

  assign busy      = (st != ST_IDLE);
  assign beat      = mem_req && mem_ack;
  assign mode_bad  = (cw[1:0] != 2'b00);
  assign res_push  = (st == ST_PUSH) && !res_full;
  assign res_word  = res_q;
  assign mem_wdata = dbuf;

  always_comb begin
    mem_req  = (st == ST_PTR) || (st == ST_CMD) || (st == ST_RD) || (st == ST_WR);
    mem_we   = (st == ST_WR);
    mem_addr = '0;
    case (st)
      ST_PTR:  mem_addr = ptr_a;
      ST_CMD:  mem_addr = cmd_a + {28'b0, idx, 2'b00};
      ST_RD:   mem_addr = src_a;
      ST_WR:   mem_addr = dst_a;
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; st_after <= ST_IDLE;
      ptr_a <= '0; cmd_a <= '0; src_a <= '0; dst_a <= '0;
      cw <= '0; dbuf <= '0; res_q <= '0; left <= '0; idx <= '0;
      last_ptr <= 1'b0; flush_pend <= 1'b0;
    end else begin
      if (st == ST_IDLE)  flush_pend <= 1'b0;
      else if (flush_req) flush_pend <= 1'b1;
      else if (st == ST_ADV) flush_pend <= 1'b0;

      case (st)
        ST_IDLE: if (start) begin
          ptr_a <= start_addr;
          st    <= ST_PTR;
        end
        ST_PTR: if (beat) begin
          last_ptr <= mem_rdata[LAST_BIT];
          cmd_a    <= field_to_addr(mem_rdata[28:0]);
          ptr_a    <= ptr_a + 32'd4;
          idx      <= 2'd0;
          st       <= ST_CMD;
        end
        ST_CMD: if (beat) begin
          case (idx)
            2'd0:    cw    <= mem_rdata;
            2'd1:    src_a <= mem_rdata;
            2'd2:    dst_a <= mem_rdata;
            default: left  <= words_of(mem_rdata);
          endcase
          idx <= idx + 2'd1;
          if (idx == 2'd3) begin
            cmd_a <= cmd_a + 32'd16;
            st    <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (mode_bad) begin
            res_q    <= result_word(1'b1, 1'b0, 1'b0, 1'b0);
            st_after <= ST_IDLE;
            st       <= ST_PUSH;
          end else if (left == '0) st <= ST_FIN;
          else                     st <= ST_RD;
        end
        ST_RD: if (beat) begin
          dbuf <= mem_rdata;
          st   <= ST_WR;
        end
        ST_WR: if (beat) begin
          src_a <= src_a + 32'd4;
          dst_a <= dst_a + 32'd4;
          left  <= left - 30'd1;
          st    <= (left == 30'd1) ? ST_FIN : ST_RD;
        end
        ST_FIN: begin
          if (cw[FORCE_BIT]) begin
            res_q    <= result_word(1'b0, 1'b0, 1'b0, 1'b1);
            st_after <= ST_ADV;
            st       <= ST_PUSH;
          end else st <= ST_ADV;
        end
        ST_ADV: begin
          if (flush_pend) begin
            if (cfg_flush_res) begin
              res_q    <= result_word(1'b0, 1'b1, 1'b0, 1'b0);
              st_after <= ST_IDLE;
              st       <= ST_PUSH;
            end else st <= ST_IDLE;
          end else if (!cw[LAST_BIT]) begin
            st <= ST_CMD;
          end else if (!last_ptr) begin
            if (cfg_top_res) begin
              res_q    <= result_word(1'b0, 1'b0, 1'b1, 1'b0);
              st_after <= ST_PTR;
              st       <= ST_PUSH;
            end else st <= ST_PTR;
          end else begin
            res_q    <= result_word(1'b0, 1'b0, 1'b1, 1'b0);
            st_after <= ST_IDLE;
            st       <= ST_PUSH;
          end
        end
        ST_PUSH: if (!res_full) st <= st_after;
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r6_err_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_push && res_word[RB_ERR]) |=> !busy);
  a_r12_flush_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_push && res_word[RB_FLUSH]) |=> !busy);
  a_r8_user_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (res_push && res_word[RB_USER]) |=> busy);
endmodule

// File: rtl/dlw_channel.sv
module dlw_channel
  import dlw_pkg::*;
#(
  parameter int RESQ_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int QCW = $clog2(RESQ_DEPTH) + 1;

  logic            pend_v;
  logic [31:0]     pend_a;
  logic [2:0]      cfg;
  logic            busy, start;
  logic            wr_cmd, wr_cfg, wr_flush, rd_pop;
  logic            res_push, q_full, q_empty;
  logic [31:0]     res_word, q_head;
  logic [QCW-1:0]  q_count;
  logic [1:0]      ptr_cnt;
  logic [31:0]     status_w;

  assign wr_cmd   = reg_we && (reg_addr == RA_CMDPTR);
  assign wr_cfg   = reg_we && (reg_addr == RA_CONFIG);
  assign wr_flush = reg_we && (reg_addr == RA_FLUSH);
  assign rd_pop   = reg_re && (reg_addr == RA_RESULT) && !q_empty;
  assign start    = pend_v && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      cfg    <= '0;
    end else begin
      if (wr_cfg) cfg <= reg_wdata[2:0];
      if (start) pend_v <= 1'b0;
      else if (wr_cmd && !pend_v && reg_wdata[31:TYPE_LO] == TYPE_PTR_LIST) begin
        pend_v <= 1'b1;
        pend_a <= field_to_addr(reg_wdata[28:0]);
      end
    end
  end

  dlw_walker u_walker (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_addr(pend_a),
    .flush_req(wr_flush),
    .cfg_flush_res(cfg[CF_FLUSH_RES]), .cfg_top_res(cfg[CF_TOP_RES]),
    .res_full(q_full), .busy(busy),
    .res_push(res_push), .res_word(res_word),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  dlw_resq #(.DEPTH(RESQ_DEPTH), .W(32)) u_resq (
    .clk(clk), .rst_n(rst_n),
    .push(res_push), .din(res_word), .pop(rd_pop),
    .dout(q_head), .count(q_count), .full(q_full), .empty(q_empty)
  );

  assign ptr_cnt  = {1'b0, busy} + {1'b0, pend_v};
  assign status_w = {3'(q_count), ptr_cnt, 25'b0, !q_empty, !pend_v};
  assign irq      = cfg[CF_IRQ] && !q_empty;

  always_comb begin
    case (reg_addr)
      RA_RESULT: reg_rdata = q_empty ? 32'b0 : q_head;
      RA_STATUS: reg_rdata = status_w;
      RA_CONFIG: reg_rdata = {29'b0, cfg};
      default:   reg_rdata = '0;
    endcase
  end

  a_r2_walk_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pend_v));
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(irq)) |-> ($past(res_push) || $past(wr_cfg)));
  a_r9_slot_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && pend_v && !start) |=> pend_v && $stable(pend_a));
endmodule

// File: tb/tb_dlw_channel.sv
module tb_dlw_channel;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LC = 32'h8000_0000;
  localparam logic [31:0] FR = 32'h0040_0000;
  localparam int NV = 5;
  localparam int V_LEN   [NV] = '{4, 12, 6, 0, 8};
  localparam int V_FR    [NV] = '{0, 0, 0, 0, 1};
  localparam int V_WORDS [NV] = '{1, 3, 2, 0, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [31:0] mem [256];
  int checks = 0, errors = 0, reqcnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlw_channel dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always @(posedge clk) begin
    if (mem_req) reqcnt <= reqcnt + 1;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic expect_res(input string r, input logic [31:0] e);
    logic [31:0] v;
    reg_read(3'd1, v);
    chk(r, v, e);
  endtask

  task automatic fill();
    for (int i = 128; i < 256; i++)
      mem[i] = (i < 192) ? (32'hA5A5_0000 | i) : (32'hDEAD_0000 | i);
  endtask

  task automatic put_cmd(input int arr, input int k, input logic [31:0] c,
                         input int s, input int d, input int len);
    mem[(arr + 16*k) / 4]     = c;
    mem[(arr + 16*k) / 4 + 1] = s;
    mem[(arr + 16*k) / 4 + 2] = d;
    mem[(arr + 16*k) / 4 + 3] = len;
  endtask

  task automatic start(input int list);
    reg_write(3'd0, 32'h2000_0000 | (list >> 3));
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    do begin
      reg_read(3'd2, s);
      n++;
    end while (s[28:27] != 2'd0 && n < 3000);
    if (n >= 3000) chk("R2 walk did not finish", 32'd1, 32'd0);
  endtask

  // compare dst words with the source pattern, then a sentinel just beyond
  task automatic check_copy(input string r, input int sw, input int dw, input int n);
    for (int k = 0; k < n; k++) chk(r, mem[dw + k], 32'hA5A5_0000 | (sw + k));
    chk({r, " sentinel"}, mem[dw + n], 32'hDEAD_0000 | (dw + n));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int rq;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(3'd2, v); chk("R1 status", v, 32'h0000_0001);
    reg_read(3'd1, v); chk("R1 result", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);

    // R2 wrong command type ignored
    rq = reqcnt;
    reg_write(3'd0, 32'h4000_0010);
    repeat (6) @(negedge clk);
    reg_read(3'd2, v); chk("R2 bad type status", v, 32'h0000_0001);
    chk("R2 bad type no traffic", rq, reqcnt);

    // table of single-command lists: R4, R7, R8
    for (int t = 0; t < NV; t++) begin
      fill();
      mem[0] = LC | (32'h040 >> 3);
      put_cmd(32'h040, 0, LC | (V_FR[t] != 0 ? FR : 32'h0), 32'h200, 32'h300, V_LEN[t]);
      start(32'h000);
      wait_idle();
      check_copy("R4 copy", 128, 192, V_WORDS[t]);
      if (V_FR[t] != 0) expect_res("R8 user result", 32'h8000_0001);
      expect_res("R7 done result", 32'h8000_0002);
      expect_res("R13 empty read", 32'h0);
    end

    // R3 / R5 two pointer entries, then R11 with per-array done
    for (int pass = 0; pass < 2; pass++) begin
      reg_write(3'd3, pass == 1 ? 32'h4 : 32'h0);
      fill();
      mem[4] = 32'h6000_0000 | (32'h040 >> 3);
      mem[5] = LC | (32'h0A0 >> 3);
      put_cmd(32'h040, 0, 32'h0, 32'h200, 32'h300, 8);
      put_cmd(32'h040, 1, LC,    32'h208, 32'h310, 4);
      put_cmd(32'h0A0, 0, LC,    32'h20C, 32'h320, 8);
      start(32'h010);
      wait_idle();
      check_copy("R5 array cmd0", 128, 192, 2);
      check_copy("R5 array cmd1", 130, 196, 1);
      check_copy("R3 second pointer", 131, 200, 2);
      if (pass == 1) expect_res("R11 array done", 32'h8000_0002);
      expect_res("R7 list done", 32'h8000_0002);
      expect_res("R11 queue empty", 32'h0);
    end
    reg_write(3'd3, 32'h0);

    // R6 bad mode
    fill();
    mem[0] = LC | (32'h040 >> 3);
    put_cmd(32'h040, 0, 32'h0,       32'h200, 32'h300, 4);
    put_cmd(32'h040, 1, LC | 32'h2,  32'h204, 32'h304, 4);
    start(32'h000);
    wait_idle();
    check_copy("R6 prior copy kept, bad cmd skipped", 128, 192, 1);
    expect_res("R6 error result", 32'h8000_0008);
    expect_res("R6 nothing more", 32'h0);

    // R9 status with a held pointer; R2 third write ignored
    fill();
    mem[0] = LC | (32'h040 >> 3);
    mem[2] = LC | (32'h060 >> 3);
    mem[6] = LC | (32'h080 >> 3);
    put_cmd(32'h040, 0, LC, 32'h200, 32'h300, 64);
    put_cmd(32'h060, 0, LC, 32'h200, 32'h380, 4);
    put_cmd(32'h080, 0, LC, 32'h200, 32'h3C0, 4);
    start(32'h000);
    start(32'h008);
    reg_read(3'd2, v); chk("R9 busy status", v, 32'h1000_0000);
    start(32'h018);
    wait_idle();
    reg_read(3'd2, v); chk("R9 idle status", v, 32'h4000_0003);
    check_copy("R9 long copy", 128, 192, 16);
    chk("R2 held pointer ran", mem[224], 32'hA5A5_0080);
    chk("R2 write to full slot ignored", mem[240], 32'hDEAD_00F0);
    expect_res("R9 first done", 32'h8000_0002);
    expect_res("R9 second done", 32'h8000_0002);

    // R13 full queue stall, R10 irq
    reg_write(3'd3, 32'h1);
    fill();
    mem[0] = LC | (32'h040 >> 3);
    for (int k = 0; k < 6; k++)
      put_cmd(32'h040, k, FR | (k == 5 ? LC : 32'h0), 32'h200, 32'h300, 0);
    start(32'h000);
    repeat (200) @(negedge clk);
    reg_read(3'd2, v); chk("R13 stalled with 4 queued", v, 32'h8800_0003);
    chk("R10 irq with results", {31'b0, irq}, 32'd1);
    for (int k = 0; k < 7; k++) begin
      expect_res("R13 ordered drain", k < 6 ? 32'h8000_0001 : 32'h8000_0002);
      repeat (30) @(negedge clk);
    end
    expect_res("R13 drained", 32'h0);
    chk("R10 irq low when empty", {31'b0, irq}, 32'd0);
    chk("R4 zero length no data", mem[192], 32'hDEAD_00C0);

    // R12 flush at command boundary
    reg_write(3'd3, 32'h2);
    fill();
    mem[0] = LC | (32'h040 >> 3);
    put_cmd(32'h040, 0, 32'h0, 32'h200, 32'h300, 32);
    put_cmd(32'h040, 1, 32'h0, 32'h220, 32'h320, 32);
    put_cmd(32'h040, 2, LC,    32'h240, 32'h340, 32);
    start(32'h000);
    repeat (15) @(negedge clk);
    reg_write(3'd4, 32'h0);
    wait_idle();
    check_copy("R12 running command finished", 128, 192, 8);
    expect_res("R12 flush result", 32'h8000_0004);
    expect_res("R12 nothing more", 32'h0);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule